// File: doc/BRIEF.md
# Processor trap entry controller

This block decides, cycle by cycle, whether a register-windowed processor takes a trap, and on the cycle it does, it updates the architectural state kept for trap handling. Inputs are a reset request, a synchronous trap request with its 8-bit code, and a 4-bit external interrupt level. The block holds the trap-enable bit, the supervisor and previous-supervisor bits, the processor interrupt level (PIL), the current window pointer, the trap base register with its code field, and the PC/nPC pair. When a trap is taken it points PC/nPC at the handler and emits one save request. That request carries the interrupted PC/nPC pair and the number of the newly selected window, so the register file can store the pair in local registers 1 and 2 of that window.

Trap entry changes the status state only in ways a return can undo: it clears the enable bit, moves the supervisor bit into the previous-supervisor bit, sets supervisor and steps the window pointer down. It never saves the status word and never raises the PIL. While the enable bit is clear, interrupts are ignored. A synchronous request in that state does not vector: it halts the block in an error mode that only a reset request leaves. A return input re-arms traps. A step input advances PC/nPC when no trap is taken. All state is updated on the rising clock edge, so every effect appears on the outputs one cycle after the inputs that cause it.

Top module: `trap_entry_ctrl`

## Requirements
- R1: Every taken trap (reset, synchronous or interrupt) clears `trap_en`, copies `sup` into `prev_sup`, sets `sup` to 1, and sets `cwp` to `cwp-1` modulo `NWIN`, so window 0 goes to `NWIN-1`.
- R2: In the cycle after a trap is taken, `trap_taken` and `save_we` are 1 for one cycle, and `save_win` equals the new `cwp`.
- R3: `tbr` is formed as follows: bits [31:12] hold the base written through `tba_we`/`tba_wdata[31:12]`, bits [11:4] hold the code of the last trap taken, and bits [3:0] are zero. An interrupt of level n uses code 0x10+n, a reset request uses code 0x00, and a synchronous trap uses `sync_tt`.
- R4: A synchronous or interrupt trap loads `pc` with the new `tbr` value and `npc` with `tbr+4`. A reset request loads `pc` with 0 and `npc` with 4.
- R5: Taking a trap leaves `pil` unchanged. Only `pil_we` writes `pil`.
- R6: An interrupt is taken only when `irq_level` is greater than `pil`. A level equal to or below the PIL, and level 0 always, has no effect.
- R7: While `trap_en` is 0, interrupt requests are ignored. A synchronous request in that state sets `error_mode` instead of vectoring. While `error_mode` is set, `step`, `rett`, `sync_req` and interrupts change nothing, and only a reset request clears it.
- R8: An interrupt trap saves the pair after the current instruction (`save_pc`=old `npc`, `save_npc`=old `npc`+4). A synchronous or reset trap saves the current pair (`save_pc`=old `pc`, `save_npc`=old `npc`).
- R9: Priority from highest to lowest is: reset request, synchronous request, interrupt, then `rett`/`step`. A lower-priority input in the same cycle as a taken trap has no effect.
- R10: `rett` with no trap in the same cycle sets `trap_en` to 1, copies `prev_sup` into `sup`, and sets `cwp` to `cwp+1` modulo `NWIN`.
- R11: `step` with no trap in the same cycle moves `npc` into `pc` and loads `npc` with `npc+4`.
- R12: `rst` (synchronous, active high) sets `trap_en`=0, `sup`=1, `prev_sup`=0, `pil`=0, `cwp`=0, `tbr`=0, `pc`=0, `npc`=4, `error_mode`=0 and clears both pulse outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| reset_req | input | 1 | Reset trap request |
| sync_req | input | 1 | Synchronous trap request |
| sync_tt | input | 8 | Code of the synchronous trap |
| irq_level | input | 4 | External interrupt level, 0 = none |
| rett | input | 1 | Return from trap: re-arm traps, restore mode, window up |
| step | input | 1 | Current instruction retires; advance PC/nPC |
| pil_we | input | 1 | Write enable for the PIL |
| pil_wdata | input | 4 | New PIL value |
| tba_we | input | 1 | Write enable for the trap base |
| tba_wdata | input | ADDR_W | New trap base; bits [ADDR_W-1:12] are kept |
| pc | output | ADDR_W | Current PC |
| npc | output | ADDR_W | Next PC |
| tbr | output | ADDR_W | Trap base register with trap code field |
| trap_en | output | 1 | Trap-enable bit |
| sup | output | 1 | Supervisor bit |
| prev_sup | output | 1 | Previous-supervisor bit |
| pil | output | 4 | Processor interrupt level |
| cwp | output | CWP_W | Current window pointer |
| error_mode | output | 1 | Halted after a synchronous trap with traps disabled |
| trap_taken | output | 1 | One-cycle pulse after a trap is taken |
| save_we | output | 1 | Request to save the old PC/nPC into locals 1 and 2 |
| save_win | output | CWP_W | Window that receives the save |
| save_pc | output | ADDR_W | Old PC value for local register 1 |
| save_npc | output | ADDR_W | Old nPC value for local register 2 |

## Verification
Interrupt entry is driven with levels above, equal to and below a nonzero PIL, and again while the enable bit is clear. These cases separate a correct `>` comparison from `>=` and show whether the enable gate works. Synchronous and interrupt entries are run from different PC/nPC pairs, which tells the current-pair save apart from the following-pair save. A return is repeated until the window pointer wraps upward, and a trap is then taken from window 0, so both modulo directions are covered. Requests are also made to collide: a synchronous request with an interrupt, and a reset request with a synchronous request while halted. These cases fix the priority order and show the way out of error mode.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

    localparam int TT_W  = 8;
    localparam int PIL_W = 4;
    localparam int TBA_LSB = 12;

    localparam logic [TT_W-1:0] TT_RESET    = 8'h00;
    localparam logic [TT_W-1:0] TT_IRQ_BASE = 8'h10;

    // What the controller does in a given cycle
    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_RESET,
        ACT_SYNC,
        ACT_IRQ,
        ACT_HALT
    } trap_act_e;

    typedef struct packed {
        trap_act_e        act;
        logic [TT_W-1:0]  tt;
        logic             rett_ok;
        logic             step_ok;
    } trap_dec_t;

    function automatic logic [TT_W-1:0] irq_code(input logic [PIL_W-1:0] lvl);
        return TT_IRQ_BASE | {{(TT_W-PIL_W){1'b0}}, lvl};
    endfunction

    function automatic logic irq_qualifies(input logic [PIL_W-1:0] lvl,
                                           input logic [PIL_W-1:0] mask);
        return lvl > mask;
    endfunction

    function automatic logic is_vectoring(input trap_act_e a);
        return (a == ACT_RESET) || (a == ACT_SYNC) || (a == ACT_IRQ);
    endfunction

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_entry_pkg::*;
(
    input  logic              reset_req,
    input  logic              sync_req,
    input  logic [TT_W-1:0]   sync_tt,
    input  logic [PIL_W-1:0]  irq_level,
    input  logic [PIL_W-1:0]  pil,
    input  logic              trap_en,
    input  logic              halted,
    input  logic              rett,
    input  logic              step,
    output trap_dec_t         dec
);

    // Fixed priority: reset request, synchronous, interrupt, then rett/step
    always_comb begin
        dec.act     = ACT_NONE;
        dec.tt      = '0;
        dec.rett_ok = 1'b0;
        dec.step_ok = 1'b0;
        if (reset_req) begin
            dec.act = ACT_RESET;
            dec.tt  = TT_RESET;
        end else if (halted) begin
            dec.act = ACT_NONE;
        end else if (sync_req) begin
            if (trap_en) begin
                dec.act = ACT_SYNC;
                dec.tt  = sync_tt;
            end else begin
                dec.act = ACT_HALT;
            end
        end else if (trap_en && irq_qualifies(irq_level, pil)) begin
            dec.act = ACT_IRQ;
            dec.tt  = irq_code(irq_level);
        end else begin
            dec.rett_ok = rett;
            dec.step_ok = step;
        end
    end

endmodule

// File: rtl/trap_psr_unit.sv
module trap_psr_unit
    import trap_entry_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int CWP_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  trap_dec_t         dec,
    input  logic              pil_we,
    input  logic [PIL_W-1:0]  pil_wdata,
    output logic              trap_en,
    output logic              sup,
    output logic              prev_sup,
    output logic [PIL_W-1:0]  pil,
    output logic [CWP_W-1:0]  cwp,
    output logic              halted
);

    localparam logic [CWP_W-1:0] CWP_TOP = CWP_W'(NWIN - 1);

    function automatic logic [CWP_W-1:0] win_down(input logic [CWP_W-1:0] w);
        return (w == '0) ? CWP_TOP : w - 1'b1;
    endfunction

    function automatic logic [CWP_W-1:0] win_up(input logic [CWP_W-1:0] w);
        return (w == CWP_TOP) ? '0 : w + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_en  <= 1'b0;
            sup      <= 1'b1;
            prev_sup <= 1'b0;
            pil      <= '0;
            cwp      <= '0;
            halted   <= 1'b0;
        end else begin
            if (pil_we)
                pil <= pil_wdata;
            case (dec.act)
                ACT_RESET, ACT_SYNC, ACT_IRQ: begin
                    trap_en  <= 1'b0;
                    prev_sup <= sup;
                    sup      <= 1'b1;
                    cwp      <= win_down(cwp);
                    if (dec.act == ACT_RESET)
                        halted <= 1'b0;
                end
                ACT_HALT: begin
                    halted <= 1'b1;
                end
                default: begin
                    if (dec.rett_ok) begin
                        trap_en <= 1'b1;
                        sup     <= prev_sup;
                        cwp     <= win_up(cwp);
                    end
                end
            endcase
        end
    end

    // R1: entry is reversible and disables traps
    p_entry_et_r1: assert property (@(posedge clk) disable iff (rst)
        is_vectoring(dec.act) |=> !trap_en && sup && (prev_sup == $past(sup)));

    p_entry_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (is_vectoring(dec.act) && cwp == '0) |=> (cwp == CWP_TOP));

    // R5: the mask level is not touched by trap entry
    p_pil_kept_r5: assert property (@(posedge clk) disable iff (rst)
        (is_vectoring(dec.act) && !pil_we) |=> $stable(pil));

    // R10: return re-arms traps and restores mode
    p_return_r10: assert property (@(posedge clk) disable iff (rst)
        dec.rett_ok |=> trap_en && (sup == $past(prev_sup)));

endmodule

// File: rtl/trap_pc_unit.sv
module trap_pc_unit
    import trap_entry_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  trap_dec_t         dec,
    input  logic              tba_we,
    input  logic [ADDR_W-1:0] tba_wdata,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] npc,
    output logic [ADDR_W-1:0] tbr,
    output logic              trap_taken,
    output logic              save_we,
    output logic [ADDR_W-1:0] save_pc,
    output logic [ADDR_W-1:0] save_npc
);

    localparam int TBA_W = ADDR_W - TBA_LSB;
    localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(4);

    logic [TBA_W-1:0] tba;
    logic [TT_W-1:0]  tt_q;
    logic [ADDR_W-1:0] vec;

    assign vec = {tba, dec.tt, 4'b0000};
    assign tbr = {tba, tt_q, 4'b0000};

    always_ff @(posedge clk) begin
        if (rst) begin
            pc         <= '0;
            npc        <= INSN_BYTES;
            tba        <= '0;
            tt_q       <= '0;
            trap_taken <= 1'b0;
            save_we    <= 1'b0;
            save_pc    <= '0;
            save_npc   <= '0;
        end else begin
            trap_taken <= 1'b0;
            save_we    <= 1'b0;
            if (tba_we)
                tba <= tba_wdata[ADDR_W-1:TBA_LSB];
            case (dec.act)
                ACT_RESET: begin
                    tt_q       <= TT_RESET;
                    pc         <= '0;
                    npc        <= INSN_BYTES;
                    save_pc    <= pc;
                    save_npc   <= npc;
                    save_we    <= 1'b1;
                    trap_taken <= 1'b1;
                end
                ACT_SYNC: begin
                    tt_q       <= dec.tt;
                    pc         <= vec;
                    npc        <= vec + INSN_BYTES;
                    save_pc    <= pc;
                    save_npc   <= npc;
                    save_we    <= 1'b1;
                    trap_taken <= 1'b1;
                end
                ACT_IRQ: begin
                    tt_q       <= dec.tt;
                    pc         <= vec;
                    npc        <= vec + INSN_BYTES;
                    save_pc    <= npc;
                    save_npc   <= npc + INSN_BYTES;
                    save_we    <= 1'b1;
                    trap_taken <= 1'b1;
                end
                default: begin
                    if (dec.step_ok) begin
                        pc  <= npc;
                        npc <= npc + INSN_BYTES;
                    end
                end
            endcase
        end
    end

    // R4: handler entry pair is sequential and aligned to the code field
    p_vector_pair_r4: assert property (@(posedge clk) disable iff (rst)
        (dec.act == ACT_SYNC || dec.act == ACT_IRQ) |=>
            (npc == pc + INSN_BYTES) && (pc == tbr));

    p_reset_vec_r4: assert property (@(posedge clk) disable iff (rst)
        (dec.act == ACT_RESET) |=> (pc == '0) && (npc == INSN_BYTES));

    // R8: which pair is saved depends on the trap class
    p_async_pair_r8: assert property (@(posedge clk) disable iff (rst)
        (dec.act == ACT_IRQ) |=>
            (save_pc == $past(npc)) && (save_npc == $past(npc) + INSN_BYTES));

    p_sync_pair_r8: assert property (@(posedge clk) disable iff (rst)
        (dec.act == ACT_SYNC) |=> (save_pc == $past(pc)) && (save_npc == $past(npc)));

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
    import trap_entry_pkg::*;
#(
    parameter int NWIN   = 8,
    parameter int ADDR_W = 32,
    localparam int CWP_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reset_req,
    input  logic              sync_req,
    input  logic [7:0]        sync_tt,
    input  logic [3:0]        irq_level,
    input  logic              rett,
    input  logic              step,
    input  logic              pil_we,
    input  logic [3:0]        pil_wdata,
    input  logic              tba_we,
    input  logic [ADDR_W-1:0] tba_wdata,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] npc,
    output logic [ADDR_W-1:0] tbr,
    output logic              trap_en,
    output logic              sup,
    output logic              prev_sup,
    output logic [3:0]        pil,
    output logic [CWP_W-1:0]  cwp,
    output logic              error_mode,
    output logic              trap_taken,
    output logic              save_we,
    output logic [CWP_W-1:0]  save_win,
    output logic [ADDR_W-1:0] save_pc,
    output logic [ADDR_W-1:0] save_npc
);

    trap_dec_t dec;
    logic      halted;

    trap_arbiter u_arb (
        .reset_req (reset_req),
        .sync_req  (sync_req),
        .sync_tt   (sync_tt),
        .irq_level (irq_level),
        .pil       (pil),
        .trap_en   (trap_en),
        .halted    (halted),
        .rett      (rett),
        .step      (step),
        .dec       (dec)
    );

    trap_psr_unit #(.NWIN(NWIN)) u_psr (
        .clk       (clk),
        .rst       (rst),
        .dec       (dec),
        .pil_we    (pil_we),
        .pil_wdata (pil_wdata),
        .trap_en   (trap_en),
        .sup       (sup),
        .prev_sup  (prev_sup),
        .pil       (pil),
        .cwp       (cwp),
        .halted    (halted)
    );

    trap_pc_unit #(.ADDR_W(ADDR_W)) u_pc (
        .clk        (clk),
        .rst        (rst),
        .dec        (dec),
        .tba_we     (tba_we),
        .tba_wdata  (tba_wdata),
        .pc         (pc),
        .npc        (npc),
        .tbr        (tbr),
        .trap_taken (trap_taken),
        .save_we    (save_we),
        .save_pc    (save_pc),
        .save_npc   (save_npc)
    );

    assign error_mode = halted;
    // The save goes to the window selected by the trap, visible in the same cycle
    assign save_win   = cwp;

    // R7: with traps disabled, only reset or a synchronous request can act
    p_irq_gated_r7: assert property (@(posedge clk) disable iff (rst)
        (!trap_en && !reset_req && !sync_req) |=> !trap_taken);

    p_halt_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (error_mode && !reset_req) |=> error_mode && $stable(pc) && $stable(cwp));

    // R2: save request coincides with the trap pulse
    p_save_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        trap_taken |-> save_we);

endmodule

// File: tb/tb_trap_entry_ctrl.sv
module tb_trap_entry_ctrl;

    localparam int NW = 8;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst, reset_req, sync_req, rett, step, pil_we, tba_we;
    logic [7:0]  sync_tt;
    logic [3:0]  irq_level, pil_wdata;
    logic [31:0] tba_wdata;
    logic [31:0] pc, npc, tbr, save_pc, save_npc;
    logic        trap_en, sup, prev_sup, error_mode, trap_taken, save_we;
    logic [3:0]  pil;
    logic [2:0]  cwp, save_win;

    always #10 clk = ~clk;

    trap_entry_ctrl #(.NWIN(NW), .ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .reset_req(reset_req), .sync_req(sync_req),
        .sync_tt(sync_tt), .irq_level(irq_level), .rett(rett), .step(step),
        .pil_we(pil_we), .pil_wdata(pil_wdata), .tba_we(tba_we),
        .tba_wdata(tba_wdata), .pc(pc), .npc(npc), .tbr(tbr),
        .trap_en(trap_en), .sup(sup), .prev_sup(prev_sup), .pil(pil),
        .cwp(cwp), .error_mode(error_mode), .trap_taken(trap_taken),
        .save_we(save_we), .save_win(save_win), .save_pc(save_pc),
        .save_npc(save_npc)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference model state
    logic [31:0] m_pc, m_npc, m_tba;
    logic [7:0]  m_tt;
    logic [3:0]  m_pil;
    int          m_cwp;
    logic        m_et, m_s, m_ps, m_err;

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic check_state(input string req);
        chk(req, "pc", pc, m_pc);
        chk(req, "npc", npc, m_npc);
        chk(req, "cwp", 32'(cwp), 32'(m_cwp));
        chk(req, "trap_en", 32'(trap_en), 32'(m_et));
        chk(req, "sup", 32'(sup), 32'(m_s));
        chk(req, "prev_sup", 32'(prev_sup), 32'(m_ps));
        chk(req, "pil", 32'(pil), 32'(m_pil));
        chk(req, "tbr", tbr, {m_tba[31:12], m_tt, 4'h0});
        chk(req, "error_mode", 32'(error_mode), 32'(m_err));
    endtask

    task automatic idle_inputs();
        reset_req = 0; sync_req = 0; sync_tt = 0; irq_level = 0; rett = 0;
        step = 0; pil_we = 0; pil_wdata = 0; tba_we = 0; tba_wdata = 0;
    endtask

    // Model of a taken trap; code and kind decide the vector and saved pair
    task automatic model_trap(input logic [7:0] code, input bit is_reset,
                              input bit is_irq, input string req);
        logic [31:0] exp_spc, exp_snpc;
        exp_spc  = is_irq ? m_npc : m_pc;
        exp_snpc = is_irq ? m_npc + 32'd4 : m_npc;
        m_ps  = m_s;
        m_s   = 1'b1;
        m_et  = 1'b0;
        m_cwp = (m_cwp + NW - 1) % NW;
        m_tt  = code;
        m_err = 1'b0;
        if (is_reset) begin
            m_pc = 32'h0; m_npc = 32'h4;
        end else begin
            m_pc = {m_tba[31:12], code, 4'h0}; m_npc = m_pc + 32'd4;
        end
        chk(req, "trap_taken", 32'(trap_taken), 32'd1);
        chk("R2", "save_we", 32'(save_we), 32'd1);
        chk("R2", "save_win", 32'(save_win), 32'(m_cwp));
        chk("R8", "save_pc", save_pc, exp_spc);
        chk("R8", "save_npc", save_npc, exp_snpc);
    endtask

    task automatic t_reset();
        idle_inputs();
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        m_pc = 0; m_npc = 4; m_tba = 0; m_tt = 0; m_pil = 0; m_cwp = 0;
        m_et = 0; m_s = 1; m_ps = 0; m_err = 0;
        chk("R12", "trap_taken", 32'(trap_taken), 32'd0);
        chk("R12", "save_we", 32'(save_we), 32'd0);
        check_state("R12");
    endtask

    task automatic t_rett(input int n);
        for (int i = 0; i < n; i++) begin
            rett = 1;
            @(negedge clk);
            rett = 0;
            if (!m_err) begin
                m_et = 1; m_s = m_ps; m_cwp = (m_cwp + 1) % NW;
            end
        end
        check_state("R10");
    endtask

    task automatic t_step(input int n);
        step = 1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            m_pc = m_npc; m_npc = m_npc + 32'd4;
        end
        step = 0;
        check_state("R11");
    endtask

    task automatic t_tba(input logic [31:0] v);
        tba_we = 1; tba_wdata = v;
        @(negedge clk);
        tba_we = 0;
        m_tba = {v[31:12], 12'h0};
        check_state("R3");
    endtask

    task automatic t_pil(input logic [3:0] v);
        pil_we = 1; pil_wdata = v;
        @(negedge clk);
        pil_we = 0;
        m_pil = v;
        check_state("R5");
    endtask

    // Interrupt of a given level; the model decides whether it is taken
    task automatic t_irq(input logic [3:0] lvl, input string req);
        bit take;
        take = m_et && !m_err && (lvl > m_pil);
        irq_level = lvl;
        step = 1;  // must be overridden when the interrupt is taken
        @(negedge clk);
        irq_level = 0; step = 0;
        if (take) begin
            model_trap(8'h10 + {4'h0, lvl}, 0, 1, req);
        end else begin
            chk(req, "trap_taken(ignored irq)", 32'(trap_taken), 32'd0);
            if (!m_err) begin
                m_pc = m_npc; m_npc = m_npc + 32'd4;
            end
        end
        check_state(req);
    endtask

    task automatic t_sync(input logic [7:0] code, input logic [3:0] lvl, input string req);
        bit en;
        en = m_et;
        sync_req = 1; sync_tt = code; irq_level = lvl; rett = 1;
        @(negedge clk);
        sync_req = 0; irq_level = 0; rett = 0;
        if (en) begin
            model_trap(code, 0, 0, req);
        end else begin
            m_err = 1;
            chk("R7", "trap_taken(halt)", 32'(trap_taken), 32'd0);
        end
        check_state(req);
    endtask

    task automatic t_halt_hold();
        step = 1; rett = 1; irq_level = 4'hF; sync_req = 1; sync_tt = 8'h33;
        repeat (3) @(negedge clk);
        step = 0; rett = 0; irq_level = 0; sync_req = 0;
        chk("R7", "trap_taken(halted)", 32'(trap_taken), 32'd0);
        check_state("R7");
    endtask

    task automatic t_reset_req();
        reset_req = 1; sync_req = 1; sync_tt = 8'h44; step = 1;
        @(negedge clk);
        reset_req = 0; sync_req = 0; step = 0;
        model_trap(8'h00, 1, 0, "R9");
        check_state("R4");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1;
        @(negedge clk);
        t_reset();                      // R12
        t_irq(4'h9, "R7");              // traps disabled after reset: ignored
        t_rett(1);                      // R10: window 1, user mode
        t_step(3);                      // R11
        t_tba(32'h4000_0ABC);           // R3: low bits dropped
        t_irq(4'h5, "R6");              // taken, code 0x15, following pair saved (R8)
        t_irq(4'hF, "R7");              // enable clear: ignored
        t_rett(1);
        t_pil(4'h7);
        t_irq(4'h7, "R6");              // equal to PIL: ignored
        t_irq(4'h3, "R6");              // below PIL: ignored
        t_irq(4'h8, "R5");              // taken, PIL stays 7
        t_rett(8);                      // R10: window wraps upward to 0
        t_step(2);
        t_sync(8'h2A, 4'hF, "R9");      // sync beats interrupt, window 0 -> 7 (R1)
        t_sync(8'h2B, 4'h0, "R7");      // traps disabled: error mode
        t_halt_hold();                  // R7
        t_reset_req();                  // R9: reset request beats sync, clears halt
        t_rett(1);
        t_sync(8'h05, 4'h0, "R1");      // plain synchronous trap after restart
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule